// File: doc/BRIEF.md
# DMA Channel Control and Status Register

This block holds the per-channel control word that software uses to steer a descriptor-driven DMA sequencer. It is a 32-bit register. The lower half carries the control flags and an 8-bit device status field. The upper half of every write is a bit-enable mask: a lower bit changes only when its partner sixteen positions higher is 1. Software can therefore set one flag, or clear one, with a single write and without reading the register first. Two writes to different flags cannot overwrite each other.

The register drives its flags to the sequencer as sideband outputs. The sequencer reports back the state it owns (the active, dead and branch flags) through per-flag update strobes. Software writes to those three flags are ignored, with one exception: clearing the run flag also drops active. The flush and wake requests are self-clearing. A request that software sets produces a one-cycle pulse toward the sequencer, and the flag reads back zero once the sequencer acknowledges it. Bus bytes are little-endian: byte lane 0 holds bits 7:0. A parameter inserts a byte swap for a bus of the opposite order.

Top module: `chan_ctrl_reg`

## Requirements
- R1: After a synchronous active-low reset every flag, the status field, both request pulses and the read word are zero.
- R2: On a write, the status field bits 7:0, pause (bit 14) and run (bit 15) each take the data value of their bit when the enable bit at position+16 is 1. Data 1 with enable 1 sets the bit. Data 0 with enable 1 clears it.
- R3: A write whose upper half is all zero leaves every bit of the register unchanged.
- R4: Bit 9 and the whole upper half of the read word always read zero.
- R5: Software writes to branch (bit 8), active (bit 10) and dead (bit 11) have no effect, whatever their data and enable bits.
- R6: A write that clears run (enable bit 31 = 1, data bit 15 = 0) also clears active, unless the sequencer updates active in the same cycle.
- R7: The sequencer update strobes are indexed 0 = branch, 1 = active, 2 = dead. When a strobe is high, the matching flag takes the update value at that clock edge. This takes priority over any software effect on the same flag.
- R8: A write with data 1 and enable 1 on flush (bit 13) or wake (bit 12) sets that flag. It also raises the matching pulse output for exactly the one cycle after the write edge. The flag reads 1 until the matching acknowledge input is sampled high, and then reads 0.
- R9: A software set of flush or wake in the same cycle as its acknowledge leaves the flag set. A write with enable 1 and data 0 withdraws a pending request.
- R10: With the default byte order, bus bits map directly to register bits. Byte lane 0 carries the status field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data: upper half is the enable mask, lower half the values |
| rd_data | output | 32 | Current register contents |
| seq_upd_we | input | 3 | Sequencer update strobes (0 branch, 1 active, 2 dead) |
| seq_upd_val | input | 3 | Sequencer update values, same indexing |
| flush_ack | input | 1 | Sequencer has taken the flush request |
| wake_ack | input | 1 | Sequencer has taken the wake request |
| ctl_run | output | 1 | Run flag |
| ctl_pause | output | 1 | Pause flag |
| ctl_flush_pulse | output | 1 | One-cycle flush request |
| ctl_wake_pulse | output | 1 | One-cycle wake request |
| ctl_active | output | 1 | Active flag |
| ctl_dead | output | 1 | Dead flag |
| ctl_branch | output | 1 | Branch flag |
| ctl_dev_status | output | 8 | Device status field |

## Verification
Two collisions matter. The first is a sequencer update of active in the same cycle as a software write that clears run. The second is a flush or wake acknowledge arriving in the same cycle as a new software set of that request. Directed steps drive each pair onto the same clock edge. Random stimulus also lets strobes, acknowledges and masked writes overlap freely. In every case the result is compared against a bench model that encodes the stated priorities: the sequencer wins on its own flags, and a new set wins over an acknowledge.

// File: rtl/chan_ctrl_pkg.sv
// Package: bit positions and shared types of the channel control word.
// Assumes the 16-bit control half is laid out as below; the sequencer decodes it.
package chan_ctrl_pkg;
    localparam int unsigned CTL_W     = 16;
    localparam int unsigned STAT_W    = 8;
    localparam int unsigned B_BRANCH  = 8;
    localparam int unsigned B_RSVD    = 9;
    localparam int unsigned B_ACTIVE  = 10;
    localparam int unsigned B_DEAD    = 11;
    localparam int unsigned B_WAKE    = 12;
    localparam int unsigned B_FLUSH   = 13;
    localparam int unsigned B_PAUSE   = 14;
    localparam int unsigned B_RUN     = 15;

    localparam int unsigned SEQ_N      = 3;
    localparam int unsigned SEQ_BRANCH = 0;
    localparam int unsigned SEQ_ACTIVE = 1;
    localparam int unsigned SEQ_DEAD   = 2;

    typedef struct packed {
        logic              run;
        logic              pause;
        logic              flush;
        logic              wake;
        logic              dead;
        logic              active;
        logic              rsvd;
        logic              branch;
        logic [STAT_W-1:0] status;
    } ctl_word_t;
endpackage

// File: rtl/ctrl_bus_lane.sv
// Module: byte-lane adapter between the bus and the register's little-endian view.
// Assumes BUS_W is a whole number of bytes; BYTE_SWAP=1 reverses byte order.
module ctrl_bus_lane #(
    parameter int unsigned BUS_W     = 32,
    parameter bit          BYTE_SWAP = 1'b0
) (
    input  logic [BUS_W-1:0] lane_in,
    output logic [BUS_W-1:0] lane_out
);
    localparam int unsigned NBYTES = BUS_W / 8;

    generate
        if (BYTE_SWAP) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                // Route byte b to the mirrored lane.
                assign lane_out[b*8 +: 8] = lane_in[(NBYTES-1-b)*8 +: 8];
            end
        end else begin : g_direct
            // Lanes already match the register order.
            assign lane_out = lane_in;
        end
    endgenerate
endmodule

// File: rtl/ctrl_sw_bits.sv
// Module: software-owned bits (status field, pause, run) under a per-bit write mask.
// Assumes the caller has split the write word into values and enables.
module ctrl_sw_bits
    import chan_ctrl_pkg::*;
#(
    parameter int unsigned HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_val,
    input  logic [HALF_W-1:0] wr_msk,
    output logic [STAT_W-1:0] status,
    output logic              run,
    output logic              pause
);
    // Status field: each bit follows its value only where enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (wr_en) begin
            status <= (status & ~wr_msk[STAT_W-1:0]) | (wr_val[STAT_W-1:0] & wr_msk[STAT_W-1:0]);
        end
    end

    // Run and pause flags: masked update of two single bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            pause <= 1'b0;
        end else if (wr_en) begin
            if (wr_msk[B_RUN])   run   <= wr_val[B_RUN];
            if (wr_msk[B_PAUSE]) pause <= wr_val[B_PAUSE];
        end
    end
endmodule

// File: rtl/ctrl_req_bit.sv
// Module: one self-clearing request flag with a one-cycle pulse to the sequencer.
// Assumes ack is held for at least one cycle; a new set beats a same-cycle ack.
module ctrl_req_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic ack,
    output logic pending,
    output logic pulse
);
    // Pending flag: set by software, dropped by withdrawal or acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (sw_set) begin
            pending <= 1'b1;
        end else if (sw_clr || ack) begin
            pending <= 1'b0;
        end
    end

    // Pulse: one cycle after each software set.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= sw_set;
    end
endmodule

// File: rtl/ctrl_seq_flags.sv
// Module: sequencer-owned flags (branch, active, dead).
// Assumes the sequencer strobes have priority; software only drops active via run clear.
module ctrl_seq_flags
    import chan_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEQ_N-1:0] upd_we,
    input  logic [SEQ_N-1:0] upd_val,
    input  logic             run_clr,
    output logic [SEQ_N-1:0] flags
);
    // One register per flag; only the active flag has a software path.
    generate
        for (genvar i = 0; i < SEQ_N; i++) begin : g_flag
            if (i == SEQ_ACTIVE) begin : g_act
                // Active: the strobe wins, otherwise a run clear drops it.
                always_ff @(posedge clk) begin
                    if (!rst_n)         flags[i] <= 1'b0;
                    else if (upd_we[i]) flags[i] <= upd_val[i];
                    else if (run_clr)   flags[i] <= 1'b0;
                end
            end else begin : g_plain
                // Branch and dead: loaded only by the sequencer.
                always_ff @(posedge clk) begin
                    if (!rst_n)         flags[i] <= 1'b0;
                    else if (upd_we[i]) flags[i] <= upd_val[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/chan_ctrl_reg.sv
// Module: channel control/status register with masked writes and sequencer sideband.
// Assumes a single write port; reads are combinational from the stored bits.
module chan_ctrl_reg
    import chan_ctrl_pkg::*;
#(
    parameter int unsigned BUS_W     = 32,
    parameter bit          BYTE_SWAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [SEQ_N-1:0]  seq_upd_we,
    input  logic [SEQ_N-1:0]  seq_upd_val,
    input  logic              flush_ack,
    input  logic              wake_ack,
    output logic              ctl_run,
    output logic              ctl_pause,
    output logic              ctl_flush_pulse,
    output logic              ctl_wake_pulse,
    output logic              ctl_active,
    output logic              ctl_dead,
    output logic              ctl_branch,
    output logic [STAT_W-1:0] ctl_dev_status
);
    localparam int unsigned HALF_W = BUS_W / 2;

    logic [BUS_W-1:0]  wr_word;
    logic [BUS_W-1:0]  rd_word;
    logic [HALF_W-1:0] wr_val;
    logic [HALF_W-1:0] wr_msk;
    logic [SEQ_N-1:0]  seq_flags;
    logic              run_clr;
    logic              flush_pend;
    logic              wake_pend;
    ctl_word_t         cur;

    ctrl_bus_lane #(.BUS_W(BUS_W), .BYTE_SWAP(BYTE_SWAP)) u_wr_lane (
        .lane_in  (wr_data),
        .lane_out (wr_word)
    );

    // Split the write word into values and the enable mask.
    always_comb begin
        wr_val  = wr_word[HALF_W-1:0];
        wr_msk  = wr_word[BUS_W-1:HALF_W];
        run_clr = wr_en && wr_msk[B_RUN] && !wr_val[B_RUN];
    end

    ctrl_sw_bits #(.HALF_W(HALF_W)) u_sw (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_val (wr_val),
        .wr_msk (wr_msk),
        .status (ctl_dev_status),
        .run    (ctl_run),
        .pause  (ctl_pause)
    );

    ctrl_req_bit u_flush (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_set  (wr_en && wr_msk[B_FLUSH] && wr_val[B_FLUSH]),
        .sw_clr  (wr_en && wr_msk[B_FLUSH] && !wr_val[B_FLUSH]),
        .ack     (flush_ack),
        .pending (flush_pend),
        .pulse   (ctl_flush_pulse)
    );

    ctrl_req_bit u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_set  (wr_en && wr_msk[B_WAKE] && wr_val[B_WAKE]),
        .sw_clr  (wr_en && wr_msk[B_WAKE] && !wr_val[B_WAKE]),
        .ack     (wake_ack),
        .pending (wake_pend),
        .pulse   (ctl_wake_pulse)
    );

    ctrl_seq_flags u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_we  (seq_upd_we),
        .upd_val (seq_upd_val),
        .run_clr (run_clr),
        .flags   (seq_flags)
    );

    // Assemble the readable control word; reserved bit and upper half are zero.
    always_comb begin
        ctl_branch = seq_flags[SEQ_BRANCH];
        ctl_active = seq_flags[SEQ_ACTIVE];
        ctl_dead   = seq_flags[SEQ_DEAD];
        cur.run    = ctl_run;
        cur.pause  = ctl_pause;
        cur.flush  = flush_pend;
        cur.wake   = wake_pend;
        cur.dead   = ctl_dead;
        cur.active = ctl_active;
        cur.rsvd   = 1'b0;
        cur.branch = ctl_branch;
        cur.status = ctl_dev_status;
        rd_word    = '0;
        rd_word[CTL_W-1:0] = cur;
    end

    ctrl_bus_lane #(.BUS_W(BUS_W), .BYTE_SWAP(BYTE_SWAP)) u_rd_lane (
        .lane_in  (rd_word),
        .lane_out (rd_data)
    );
endmodule

// File: rtl/chan_ctrl_reg_chk.sv
// Module: property checker for chan_ctrl_reg, bound to every instance.
// Assumes it sees the register's logical (lane-corrected) write and read words.
module chan_ctrl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_word,
    input logic [31:0] rd_word,
    input logic [2:0]  seq_upd_we,
    input logic [2:0]  seq_upd_val,
    input logic        flush_ack,
    input logic        wake_ack,
    input logic        ctl_active,
    input logic        ctl_dead,
    input logic        ctl_flush_pulse
);
    p_mask_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word[31:16] == 16'h0 && seq_upd_we == 3'b000 && !flush_ack && !wake_ack)
        |=> $stable(rd_word));

    p_rsvd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word[9] == 1'b0 && rd_word[31:16] == 16'h0);

    p_dead_sw_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_upd_we[2] |=> $stable(ctl_dead));

    p_run_clear_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_word[31] && !wr_word[15] && !seq_upd_we[1]) |=> !ctl_active);

    p_seq_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_upd_we[1] |=> ctl_active == $past(seq_upd_val[1]));

    p_flush_pulse_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_flush_pulse |-> $past(wr_en && wr_word[29] && wr_word[13]));
endmodule

bind chan_ctrl_reg chan_ctrl_reg_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_word         (wr_word),
    .rd_word         (rd_word),
    .seq_upd_we      (seq_upd_we),
    .seq_upd_val     (seq_upd_val),
    .flush_ack       (flush_ack),
    .wake_ack        (wake_ack),
    .ctl_active      (ctl_active),
    .ctl_dead        (ctl_dead),
    .ctl_flush_pulse (ctl_flush_pulse)
);

// File: tb/chan_ctrl_reg_test.sv
// Bench: directed collisions plus seeded random traffic against a behavioural model.
module chan_ctrl_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  seq_upd_we = '0;
    logic [2:0]  seq_upd_val = '0;
    logic        flush_ack = 1'b0;
    logic        wake_ack = 1'b0;
    logic        ctl_run, ctl_pause, ctl_flush_pulse, ctl_wake_pulse;
    logic        ctl_active, ctl_dead, ctl_branch;
    logic [7:0]  ctl_dev_status;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model state
    logic [7:0] m_stat;
    logic m_run, m_pause, m_flush, m_wake, m_dead, m_active, m_branch, m_fp, m_wp;

    always #2.5 clk = ~clk;

    chan_ctrl_reg uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .seq_upd_we(seq_upd_we), .seq_upd_val(seq_upd_val),
        .flush_ack(flush_ack), .wake_ack(wake_ack),
        .ctl_run(ctl_run), .ctl_pause(ctl_pause),
        .ctl_flush_pulse(ctl_flush_pulse), .ctl_wake_pulse(ctl_wake_pulse),
        .ctl_active(ctl_active), .ctl_dead(ctl_dead), .ctl_branch(ctl_branch),
        .ctl_dev_status(ctl_dev_status)
    );

    function automatic logic [31:0] exp_word();
        return {16'h0, m_run, m_pause, m_flush, m_wake, m_dead, m_active, 1'b0, m_branch, m_stat};
    endfunction

    function automatic logic [9:0] exp_side();
        return {m_run, m_pause, m_fp, m_wp, m_active, m_dead, m_branch, 3'b000};
    endfunction

    task automatic model_reset();
        m_stat = '0; m_run = 0; m_pause = 0; m_flush = 0; m_wake = 0;
        m_dead = 0; m_active = 0; m_branch = 0; m_fp = 0; m_wp = 0;
    endtask

    // Next state from the requirements, given the inputs of one cycle.
    task automatic model_step(input bit w, input logic [31:0] d, input logic [2:0] we,
                              input logic [2:0] v, input bit fa, input bit wa);
        logic [15:0] en = w ? d[31:16] : 16'h0;
        logic [15:0] dv = d[15:0];
        m_stat = (m_stat & ~en[7:0]) | (dv[7:0] & en[7:0]);
        if (en[15]) m_run = dv[15];
        if (en[14]) m_pause = dv[14];
        m_fp = en[13] && dv[13];
        m_wp = en[12] && dv[12];
        if (en[13] && dv[13]) m_flush = 1; else if (en[13] || fa) m_flush = 0;
        if (en[12] && dv[12]) m_wake = 1;  else if (en[12] || wa) m_wake = 0;
        if (we[1]) m_active = v[1]; else if (en[15] && !dv[15]) m_active = 0;
        if (we[0]) m_branch = v[0];
        if (we[2]) m_dead = v[2];
    endtask

    task automatic compare(input string tag);
        logic [9:0] act_side;
        act_side = {ctl_run, ctl_pause, ctl_flush_pulse, ctl_wake_pulse,
                    ctl_active, ctl_dead, ctl_branch, 3'b000};
        n_cmp++;
        if (rd_data !== exp_word()) begin
            n_bad++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, exp_word());
        end
        n_cmp++;
        if (act_side !== exp_side() || ctl_dev_status !== m_stat) begin
            n_bad++;
            $display("FAIL %s sideband actual=%b/%h expected=%b/%h",
                     tag, act_side, ctl_dev_status, exp_side(), m_stat);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, then check after the next rising edge.
    task automatic cyc(input bit w, input logic [31:0] d, input logic [2:0] we,
                       input logic [2:0] v, input bit fa, input bit wa, input string tag);
        wr_en = w; wr_data = d; seq_upd_we = we; seq_upd_val = v;
        flush_ack = fa; wake_ack = wa;
        model_step(w, d, we, v, fa, wa);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        cyc(1, 32'h80FF_80A5, 3'b000, 3'b000, 0, 0, "R2 set run and status");
        cyc(1, 32'h40F0_4000, 3'b000, 3'b000, 0, 0, "R2 set pause clear high nibble");
        cyc(1, 32'h0000_FFFF, 3'b000, 3'b000, 0, 0, "R3 write with no enables");
        cyc(1, 32'h0F00_0F00, 3'b000, 3'b000, 0, 0, "R4 R5 write to hw flags and reserved");
        cyc(0, 32'h0,         3'b111, 3'b111, 0, 0, "R7 sequencer sets all flags");
        cyc(1, 32'h0D00_0000, 3'b000, 3'b000, 0, 0, "R5 software clear of hw flags ignored");
        cyc(1, 32'h8000_0000, 3'b000, 3'b000, 0, 0, "R6 run clear drops active");
        cyc(1, 32'h8000_8000, 3'b010, 3'b010, 0, 0, "R7 rearm");
        cyc(1, 32'h8000_0000, 3'b010, 3'b010, 0, 0, "R7 hw wins over run clear");
        cyc(1, 32'h2000_2000, 3'b000, 3'b000, 0, 0, "R8 flush set pulse");
        cyc(0, 32'h0,         3'b000, 3'b000, 0, 0, "R8 flush pulse gone, still pending");
        cyc(0, 32'h0,         3'b000, 3'b000, 1, 0, "R8 flush ack clears");
        cyc(1, 32'h1000_1000, 3'b000, 3'b000, 0, 0, "R8 wake set pulse");
        cyc(1, 32'h1000_1000, 3'b000, 3'b000, 0, 1, "R9 wake set beats ack");
        cyc(1, 32'h1000_0000, 3'b000, 3'b000, 0, 0, "R9 wake withdrawn");
        cyc(1, 32'h00FF_003C, 3'b000, 3'b000, 0, 0, "R10 byte lane 0 is status");
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] d;
            d = $urandom();
            cyc($urandom_range(0, 3) != 0, d, 3'($urandom()), 3'($urandom()),
                $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, "R2 R7 R8 random");
        end
        rst_n = 1'b0;
        wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
        model_reset();
        @(posedge clk);
        @(negedge clk);
        compare("R1 reset after traffic");
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule